// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of a shared packet buffer. The buffer is split into fixed-size pages, and packets that hold pages are identified by small packet numbers. A host writes an allocate command that carries a byte count. The block turns the byte count into a page count and then tries to reserve that many pages together with a free packet number. The attempt finishes after the command cycle, not within it. When it succeeds, the block writes the granted number into a result register and sets a completion flag. An interrupt output follows that flag whenever the host has set the mask input.

If too few pages or no free packet number exist, the request stays pending. It is tried again on every idle cycle, so it completes the cycle after a release makes room for it. A release command returns every page that a packet number holds. A release of a number that is not in use does nothing. The packet memory itself and its data access paths are outside this block.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset all pages are free and no packet number is in use. allocDone is 0, resultFail is 1, resultPkt is 0 and irq is 0.
- R2: An allocate request needs ceil(cmdBytes / PAGE_BYTES) pages, with a zero byte count treated as one page. With the defaults of 256-byte pages and a 32-page pool, 7168 bytes takes exactly 28 pages and 8191 bytes takes the whole pool.
- R3: An allocate command (cmdValid=1, cmdOp=0) clears allocDone and sets resultFail in the cycle after it is accepted.
- R4: A request that fits is granted one cycle after the command cycle. The grant sets allocDone=1 and resultFail=0 and puts the lowest unused packet number on resultPkt. These outputs hold until the next allocate command.
- R5: If the free pages are fewer than the pages the request needs, the request stays pending with allocDone=0 and resultFail=1.
- R6: A release command (cmdValid=1, cmdOp=1) naming a packet number in use frees that number and all of its pages. A pending request that now fits is granted in the cycle after the release.
- R7: A release command naming a packet number that is not in use changes no state.
- R8: irq is 1 exactly when allocDone is 1 and intMask is 1.
- R9: When all NUM_PKTS packet numbers are in use, a request stays pending even if enough pages are free.
- R10: An allocate command issued while a request is pending replaces the pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 1 | 0 = allocate, 1 = release |
| cmdBytes | input | BYTE_W | Requested byte count for an allocate command |
| cmdPkt | input | PKT_W | Packet number for a release command |
| intMask | input | 1 | Lets allocDone reach irq |
| allocDone | output | 1 | Allocation-complete status flag |
| resultFail | output | 1 | 1 while no valid grant is held (pending or none yet) |
| resultPkt | output | PKT_W | Packet number of the last grant |
| irq | output | 1 | Masked allocation interrupt |

## Verification
An allocate command accepted at clock edge k clears the status at edge k, and a request that fits is granted at edge k+1. A request unblocked by a release accepted at edge k is granted at edge k+1. irq follows allocDone and intMask with no added delay. The bench drives every command on a falling edge and holds it for exactly one rising edge. It reads the cleared status at the falling edge after edge k and the grant at the falling edge after edge k+1, so each sample lands in the cycle where its result first becomes due. Each release in the vector table is followed by a later allocate whose outcome depends on how many pages the release freed, so a stray release that freed pages would show up at the ports.

// File: rtl/pkt_page_alloc_pkg.sv
package pkt_page_alloc_pkg;

  typedef enum logic {
    OP_ALLOC   = 1'b0,
    OP_RELEASE = 1'b1
  } cmd_op_e;

  // strobes from control to datapath; never both high in one cycle
  typedef struct packed {
    logic grantEn;
    logic releaseEn;
  } dp_strobe_t;

endpackage

// File: rtl/pkt_page_alloc_dp.sv
module pkt_page_alloc_dp
  import pkt_page_alloc_pkg::*;
#(
  parameter int NUM_PKTS  = 16,
  parameter int NUM_PAGES = 32,
  parameter int NEED_W    = 6,
  localparam int PKT_W    = $clog2(NUM_PKTS),
  localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [NEED_W-1:0] needPages,
  input  logic [PKT_W-1:0]  relPkt,
  output logic              canGrant,
  output logic [PKT_W-1:0]  grantPkt,
  output logic              relHit,
  output logic [CNT_W-1:0]  freePages,
  output logic [NUM_PKTS-1:0] inUse
);

  localparam int CMP_W = CNT_W + NEED_W;

  logic [CNT_W-1:0] pageCnt [NUM_PKTS];
  logic             anyFree;
  logic [CMP_W-1:0] freeWide;
  logic [CMP_W-1:0] needWide;

  // lowest-numbered free packet: scan from the top so the lowest wins
  always_comb begin
    anyFree  = 1'b0;
    grantPkt = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!inUse[i]) begin
        anyFree  = 1'b1;
        grantPkt = PKT_W'(i);
      end
    end
  end

  assign freeWide = CMP_W'(freePages);
  assign needWide = CMP_W'(needPages);
  assign canGrant = anyFree && (freeWide >= needWide);
  assign relHit   = inUse[relPkt];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inUse     <= '0;
      freePages <= CNT_W'(NUM_PAGES);
    end else if (strb.grantEn) begin
      inUse[grantPkt] <= 1'b1;
      freePages       <= freePages - CNT_W'(needPages);
    end else if (strb.releaseEn) begin
      inUse[relPkt] <= 1'b0;
      freePages     <= freePages + pageCnt[relPkt];
    end
  end

  generate
    for (genvar g = 0; g < NUM_PKTS; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pageCnt[g] <= '0;
        end else if (strb.grantEn && grantPkt == PKT_W'(g)) begin
          pageCnt[g] <= CNT_W'(needPages);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pkt_page_alloc_ctrl.sv
module pkt_page_alloc_ctrl
  import pkt_page_alloc_pkg::*;
#(
  parameter int BYTE_W     = 13,
  parameter int PAGE_BYTES = 256,
  parameter int NUM_PKTS   = 16,
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int NEED_W     = BYTE_W + 1 - PAGE_SHIFT,
  localparam int PKT_W      = $clog2(NUM_PKTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic [BYTE_W-1:0] cmdBytes,
  input  logic              canGrant,
  input  logic [PKT_W-1:0]  grantPkt,
  input  logic              relHit,
  output dp_strobe_t        strb,
  output logic [NEED_W-1:0] needPages,
  output logic              allocDone,
  output logic              resultFail,
  output logic [PKT_W-1:0]  resultPkt
);

  logic              pending;
  logic              isAlloc;
  logic              isRel;
  logic [BYTE_W:0]   roundUp;
  logic [NEED_W-1:0] reqPages;

  assign isAlloc = cmdValid && (cmd_op_e'(cmdOp) == OP_ALLOC);
  assign isRel   = cmdValid && (cmd_op_e'(cmdOp) == OP_RELEASE);

  // round the byte count up to whole pages; zero bytes still needs a page
  assign roundUp  = {1'b0, cmdBytes} + (BYTE_W + 1)'(PAGE_BYTES - 1);
  assign reqPages = (roundUp[BYTE_W:PAGE_SHIFT] == '0) ? NEED_W'(1)
                                                      : roundUp[BYTE_W:PAGE_SHIFT];

  // a command owns its cycle; grant attempts run only on idle cycles
  always_comb begin
    strb           = '0;
    strb.releaseEn = isRel && relHit;
    strb.grantEn   = !cmdValid && pending && canGrant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      allocDone  <= 1'b0;
      resultFail <= 1'b1;
      resultPkt  <= '0;
      needPages  <= '0;
    end else if (isAlloc) begin
      pending    <= 1'b1;
      allocDone  <= 1'b0;
      resultFail <= 1'b1;
      needPages  <= reqPages;
    end else if (strb.grantEn) begin
      pending    <= 1'b0;
      allocDone  <= 1'b1;
      resultFail <= 1'b0;
      resultPkt  <= grantPkt;
    end
  end

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_page_alloc_pkg::*;
#(
  parameter int NUM_PKTS   = 16,
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 256,
  parameter int BYTE_W     = 13,
  localparam int PKT_W      = $clog2(NUM_PKTS),
  localparam int CNT_W      = $clog2(NUM_PAGES + 1),
  localparam int NEED_W     = BYTE_W + 1 - $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdOp,
  input  logic [BYTE_W-1:0] cmdBytes,
  input  logic [PKT_W-1:0]  cmdPkt,
  input  logic              intMask,
  output logic              allocDone,
  output logic              resultFail,
  output logic [PKT_W-1:0]  resultPkt,
  output logic              irq
);

  dp_strobe_t         strb;
  logic [NEED_W-1:0]  needPages;
  logic               canGrant;
  logic [PKT_W-1:0]   grantPkt;
  logic               relHit;
  logic [CNT_W-1:0]   freePages;
  logic [NUM_PKTS-1:0] inUse;

  pkt_page_alloc_ctrl #(
    .BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PKTS(NUM_PKTS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBytes(cmdBytes), .canGrant(canGrant), .grantPkt(grantPkt),
    .relHit(relHit), .strb(strb), .needPages(needPages),
    .allocDone(allocDone), .resultFail(resultFail), .resultPkt(resultPkt)
  );

  pkt_page_alloc_dp #(
    .NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES), .NEED_W(NEED_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .needPages(needPages),
    .relPkt(cmdPkt), .canGrant(canGrant), .grantPkt(grantPkt),
    .relHit(relHit), .freePages(freePages), .inUse(inUse)
  );

  assign irq = allocDone & intMask;

endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
  parameter int NUM_PKTS  = 16,
  parameter int NUM_PAGES = 32,
  localparam int PKT_W    = $clog2(NUM_PKTS),
  localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdOp,
  input logic [PKT_W-1:0]    cmdPkt,
  input logic                intMask,
  input logic                allocDone,
  input logic                resultFail,
  input logic [PKT_W-1:0]    resultPkt,
  input logic                irq,
  input logic [CNT_W-1:0]    freePages,
  input logic [NUM_PKTS-1:0] inUse
);

  a_r3_alloc_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdOp) |=> (!allocDone && resultFail));

  a_r4_done_has_valid_result: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> !resultFail);

  a_r4_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (allocDone && !(cmdValid && !cmdOp)) |=> (allocDone && $stable(resultPkt)));

  a_r7_stray_release_inert: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp && !inUse[cmdPkt]) |=> ($stable(freePages) && $stable(inUse)));

  a_r6_pool_bounded: assert property (@(posedge clk) disable iff (!rstN)
    freePages <= CNT_W'(NUM_PAGES));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !intMask |-> !irq);

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
  .NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPkt(cmdPkt),
  .intMask(intMask), .allocDone(allocDone), .resultFail(resultFail),
  .resultPkt(resultPkt), .irq(irq), .freePages(freePages), .inUse(inUse)
);

// File: tb/pkt_page_alloc_tb_top.sv
`timescale 1ns/1ps
module pkt_page_alloc_tb_top;

  localparam int BYTE_W = 13;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdValid;
  logic              cmdOp;
  logic [BYTE_W-1:0] cmdBytes;
  logic [3:0]        cmdPkt;
  logic              intMask;
  logic              allocDone;
  logic              resultFail;
  logic [3:0]        resultPkt;
  logic              irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pkt_page_alloc dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBytes(cmdBytes), .cmdPkt(cmdPkt), .intMask(intMask),
    .allocDone(allocDone), .resultFail(resultFail), .resultPkt(resultPkt),
    .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        op;
    logic [12:0] bytes;
    logic [3:0]  pkt;
    logic        expDone;
    logic        expFail;
    logic        chkPkt;
    logic [3:0]  expPkt;
  } vec_t;

  // pool of 32 pages of 256 bytes; results sampled one cycle after the command cycle
  localparam vec_t VECS [13] = '{
    '{4'd4,  1'b0, 13'd256,  4'd0, 1'b1, 1'b0, 1'b1, 4'd0}, // R4 1 page -> pkt0, 31 free
    '{4'd2,  1'b0, 13'd257,  4'd0, 1'b1, 1'b0, 1'b1, 4'd1}, // R2 2 pages -> pkt1, 29 free
    '{4'd2,  1'b0, 13'd0,    4'd0, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 zero -> 1 page, 28 free
    '{4'd2,  1'b0, 13'd7168, 4'd0, 1'b1, 1'b0, 1'b1, 4'd3}, // R2 exactly 28 pages, 0 free
    '{4'd5,  1'b0, 13'd1,    4'd0, 1'b0, 1'b1, 1'b0, 4'd0}, // R5 pending
    '{4'd6,  1'b1, 13'd0,    4'd1, 1'b1, 1'b0, 1'b1, 4'd1}, // R6 free pkt1 -> pending gets pkt1, 1 free
    '{4'd7,  1'b1, 13'd0,    4'd9, 1'b1, 1'b0, 1'b1, 4'd1}, // R7 pkt9 unused
    '{4'd7,  1'b0, 13'd512,  4'd0, 1'b0, 1'b1, 1'b0, 4'd0}, // R7 proof: still only 1 free
    '{4'd6,  1'b1, 13'd0,    4'd0, 1'b1, 1'b0, 1'b1, 4'd0}, // R6 free pkt0 -> grant pkt0, 0 free
    '{4'd6,  1'b1, 13'd0,    4'd0, 1'b1, 1'b0, 1'b1, 4'd0}, // R6 free pkt0 (2 pages) -> 2 free
    '{4'd7,  1'b1, 13'd0,    4'd0, 1'b1, 1'b0, 1'b1, 4'd0}, // R7 pkt0 already free
    '{4'd5,  1'b0, 13'd600,  4'd0, 1'b0, 1'b1, 1'b0, 4'd0}, // R5 3 pages > 2 free
    '{4'd10, 1'b0, 13'd300,  4'd0, 1'b1, 1'b0, 1'b1, 4'd0}  // R10 replaced by 2 pages -> pkt0
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // after return: the falling edge following the command's accepting edge
  task automatic issue(input logic op, input logic [BYTE_W-1:0] bytes, input logic [3:0] pkt);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdBytes = bytes;
    cmdPkt   = pkt;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 1'b0; cmdBytes = '0; cmdPkt = '0; intMask = 1'b0;
    doReset();

    // R1 reset state
    check("R1", "allocDone", 32'(allocDone), 32'd0);
    check("R1", "resultFail", 32'(resultFail), 32'd1);
    check("R1", "resultPkt", 32'(resultPkt), 32'd0);
    check("R1", "irq", 32'(irq), 32'd0);
    // R1 whole pool free: 8191 bytes = 32 pages fits
    issue(1'b0, 13'd8191, 4'd0);
    check("R3", "allocDone cleared", 32'(allocDone), 32'd0);
    check("R3", "resultFail set", 32'(resultFail), 32'd1);
    nextCycle();
    check("R1", "full pool grant done", 32'(allocDone), 32'd1);
    check("R2", "full pool grant pkt", 32'(resultPkt), 32'd0);

    // R8 masking
    check("R8", "irq masked", 32'(irq), 32'd0);
    @(negedge clk); intMask = 1'b1; #1;
    check("R8", "irq unmasked", 32'(irq), 32'd1);
    issue(1'b0, 13'd1, 4'd0);  // no pages left: pending
    check("R8", "irq after new alloc", 32'(irq), 32'd0);
    nextCycle();
    check("R5", "pool empty pending", 32'(resultFail), 32'd1);
    intMask = 1'b0;

    // vector table from a fresh pool
    doReset();
    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      issue(VECS[i].op, VECS[i].bytes, VECS[i].pkt);
      nextCycle();
      check(tag, $sformatf("vec%0d allocDone", i), 32'(allocDone), 32'(VECS[i].expDone));
      check(tag, $sformatf("vec%0d resultFail", i), 32'(resultFail), 32'(VECS[i].expFail));
      if (VECS[i].chkPkt)
        check(tag, $sformatf("vec%0d resultPkt", i), 32'(resultPkt), 32'(VECS[i].expPkt));
    end

    // R9 packet numbers exhausted while pages remain
    doReset();
    for (int n = 0; n < 16; n++) begin
      issue(1'b0, 13'd1, 4'd0);
      nextCycle();
      if (n == 15) check("R9", "last number", 32'(resultPkt), 32'd15);
    end
    issue(1'b0, 13'd1, 4'd0);
    nextCycle();
    nextCycle();
    check("R9", "no number pending done", 32'(allocDone), 32'd0);
    check("R9", "no number pending fail", 32'(resultFail), 32'd1);
    issue(1'b1, 13'd0, 4'd5);
    nextCycle();
    check("R9", "freed number granted", 32'(resultPkt), 32'd5);
    check("R6", "grant after release", 32'(allocDone), 32'd1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule